// File: doc/BRIEF.md
# Clock Source Selector and Divider Chain

This block is the digital half of a microcontroller clock controller. It takes three clocks: the main oscillator clock, the output of an external frequency-multiplying PLL, and a slow auxiliary clock. From them it builds a system clock for the peripherals and a slower clock for the CPU core. The oscillator clock first passes through an optional halving stage that gives the reference clock. The system clock comes from one of three legs. The first leg is the reference divided by sixteen, which is the low-power leg. The second is the PLL output after a post-divider of 1 to 7. The third is the auxiliary clock. The CPU clock is the system clock after a prescaler of 1 to 8.

Control comes from static register-style inputs that are synchronous to the oscillator clock. A source switch controller runs in the oscillator domain and has three states. `ST_RUN` is steady operation. `ST_STOP_OLD` withdraws the enable of the active leg and waits until that leg confirms it is off. `ST_START_NEW` makes the chosen leg current, raises its enable and waits for it to confirm it is on. The transitions are: RUN→STOP_OLD when the target source differs from the current one; STOP_OLD→START_NEW on the old leg's "off" acknowledge; START_NEW→RUN on the new leg's "on" acknowledge. Each leg resynchronises its enable with two flops and applies it on its own falling edge, so the switch never produces a runt pulse. The PLL enable and the multiplier selection are registered and passed out to the external PLL.

Top module: `ccu_clk_top`

## Requirements
- R1: After reset the system clock is the reference divided by 16 (with halving off, 16 oscillator periods with 8 high), the CPU clock equals the system clock, `pll_en_o` is 0, `osc_off_o` is 0 and `pll_mult_o` is 6.
- R2: With `ref_half_i` = 1 the reference clock is the oscillator divided by two at 50% duty, so the divide-by-16 leg gives a 32-oscillator-period system clock with a high time of 16 periods.
- R3: One oscillator cycle after its inputs change, `pll_en_o` follows `pll_en_i`, and `pll_mult_o` shows the factor chosen by `pll_mult_code_i`: 0→6, 1→8, 2→10, 3→14.
- R4: Source changes are glitch-free. At most one leg is enabled at any time. The old leg is turned off before the new leg is turned on, and during a switch no system-clock high or low phase is shorter than the shortest phase of the legs involved.
- R5: `src_sel_i` = 1 selects the PLL leg only while `pll_lock_i` is 1. While lock is low, the current source is kept.
- R6: The post-divider factor is `post_div_i` (1..7), and code 0 acts as 1. Factor 1 passes the PLL clock through. An even factor N gives N PLL periods at 50% duty. An odd factor N≥3 gives a high phase one PLL period long every N periods.
- R7: `src_sel_i` = 2 selects the auxiliary clock. `osc_off_o` is 1 only while the auxiliary leg is running and `osc_stop_i` is 1. While `osc_stop_i` is 1 the block does not leave the auxiliary source.
- R8: CPU prescaler code c (`cpu_div_i`) divides the system clock by c+1, with the same duty rule as R6: pass-through for 1, 50% for even, a one-period-high pulse for odd.
- R9: A new divider factor takes effect only at the end of the current output period. While the factor changes, no output phase is shorter than a phase of the old or the new setting.
- R10: `src_sel_i` = 3 is treated like 0 (reference divided by 16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk_i | input | 1 | Main oscillator clock; also clocks the control logic |
| pll_clk_i | input | 1 | Multiplied clock from the external PLL |
| aux_clk_i | input | 1 | Low-frequency auxiliary clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_half_i | input | 1 | 1: reference = oscillator / 2 |
| pll_en_i | input | 1 | PLL enable request |
| pll_mult_code_i | input | 2 | Multiplier selection code |
| pll_lock_i | input | 1 | PLL lock indication |
| post_div_i | input | POST_W | PLL post-divider factor (0 acts as 1) |
| src_sel_i | input | 2 | 0/3: ref/16, 1: PLL, 2: auxiliary |
| osc_stop_i | input | 1 | Request to stop the oscillator while on the auxiliary clock |
| cpu_div_i | input | CPU_W | CPU prescaler code, factor = code + 1 |
| sys_clk_o | output | 1 | System clock to the peripherals |
| cpu_clk_o | output | 1 | CPU clock |
| pll_en_o | output | 1 | Registered PLL enable to the PLL |
| pll_mult_o | output | 4 | Decoded multiplication factor to the PLL |
| osc_off_o | output | 1 | Oscillator-off command |

## Verification
The bench uses the default parameters: POST_W = 3, CPU_W = 3, LOWP_DIV = 16. With these it can reach every post-divider code (0 through 7) and every prescaler code, including the odd/even duty split and both pass-through cases. The oscillator runs at 10 ns, the PLL clock at 4 ns and the auxiliary clock at 70 ns. These three clocks are unrelated, so each switch crosses real domain boundaries. Pulse-width monitors on both output clocks watch the switches and factor changes for runt phases.

// File: rtl/ccu_pkg.sv
`timescale 1ns/1ps
package ccu_pkg;
    localparam int NSRC = 3;

    typedef enum logic [1:0] {
        SRC_REF16 = 2'd0,
        SRC_PLL   = 2'd1,
        SRC_AUX   = 2'd2
    } src_e;

    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_STOP_OLD  = 2'd1,
        ST_START_NEW = 2'd2
    } sw_st_e;

    function automatic logic [3:0] mult_factor(input logic [1:0] code);
        logic [3:0] f;
        unique case (code)
            2'd0:    f = 4'd6;
            2'd1:    f = 4'd8;
            2'd2:    f = 4'd10;
            default: f = 4'd14;
        endcase
        return f;
    endfunction
endpackage

// File: rtl/ccu_clk_div.sv
`timescale 1ns/1ps
// Programmable clock divider. Factor sampled only at period wrap.
module ccu_clk_div #(
    parameter int W = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] fac_i,
    output logic         clk_o
);
    logic [W-1:0] cnt_q, act_q, fac_eff, f, nc, half;
    logic         q_q, byp_q, wrap, nq;

    always_comb begin
        fac_eff = (fac_i == '0) ? W'(1) : fac_i;
        wrap    = (cnt_q == act_q - W'(1));
        f       = wrap ? fac_eff : act_q;
        nc      = wrap ? '0 : cnt_q + W'(1);
        half    = f >> 1;
        nq      = f[0] ? (nc == '0) : (nc < half);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            act_q <= W'(1);
            q_q   <= 1'b0;
            byp_q <= 1'b1;
        end else begin
            cnt_q <= nc;
            act_q <= f;
            q_q   <= nq;
            byp_q <= (f == W'(1));
        end
    end

    assign clk_o = byp_q ? clk_i : q_q;
endmodule

// File: rtl/ccu_clk_leg.sv
`timescale 1ns/1ps
// One gated clock leg: two-flop request sync, enable applied on falling edge.
module ccu_clk_leg #(
    parameter bit RST_ON = 1'b0
) (
    input  logic leg_clk_i,
    input  logic rst_ni,
    input  logic req_i,
    output logic en_o,
    output logic gclk_o
);
    logic [1:0] sync_q;
    logic       en_q;

    always_ff @(posedge leg_clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= {2{RST_ON}};
        else         sync_q <= {sync_q[0], req_i};
    end

    always_ff @(negedge leg_clk_i or negedge rst_ni) begin
        if (!rst_ni) en_q <= RST_ON;
        else         en_q <= sync_q[1];
    end

    assign en_o   = en_q;
    assign gclk_o = leg_clk_i & en_q;
endmodule

// File: rtl/ccu_src_fsm.sv
`timescale 1ns/1ps
// Source switch controller in the oscillator domain.
module ccu_src_fsm
    import ccu_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [1:0]      sel_i,
    input  logic            lock_i,
    input  logic            stop_i,
    input  logic [NSRC-1:0] ack_i,
    output logic [NSRC-1:0] req_o,
    output logic            osc_off_o,
    output sw_st_e          st_o,
    output src_e            cur_o,
    output src_e            nxt_o
);
    sw_st_e st_q, st_d;
    src_e   cur_q, cur_d, nxt_q, nxt_d, tgt;
    logic [NSRC-1:0] ack_s1, ack_s2;
    logic [NSRC-1:0] req_q;
    logic            off_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ack_s1 <= NSRC'(1);
            ack_s2 <= NSRC'(1);
        end else begin
            ack_s1 <= ack_i;
            ack_s2 <= ack_s1;
        end
    end

    always_comb begin
        unique case (sel_i)
            2'd1:    tgt = lock_i ? SRC_PLL : cur_q;
            2'd2:    tgt = SRC_AUX;
            default: tgt = SRC_REF16;
        endcase
    end

    always_comb begin
        st_d  = st_q;
        cur_d = cur_q;
        nxt_d = nxt_q;
        unique case (st_q)
            ST_RUN: begin
                if (tgt != cur_q && !(cur_q == SRC_AUX && stop_i)) begin
                    st_d  = ST_STOP_OLD;
                    nxt_d = tgt;
                end
            end
            ST_STOP_OLD: begin
                if (!ack_s2[cur_q]) begin
                    st_d  = ST_START_NEW;
                    cur_d = nxt_q;
                end
            end
            ST_START_NEW: begin
                if (ack_s2[cur_q]) st_d = ST_RUN;
            end
            default: st_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q  <= ST_RUN;
            cur_q <= SRC_REF16;
            nxt_q <= SRC_REF16;
        end else begin
            st_q  <= st_d;
            cur_q <= cur_d;
            nxt_q <= nxt_d;
        end
    end

    // outputs
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            req_q <= NSRC'(1);
            off_q <= 1'b0;
        end else begin
            req_q <= (st_d == ST_STOP_OLD) ? '0 : (NSRC'(1) << cur_d);
            off_q <= (st_d == ST_RUN) && (cur_d == SRC_AUX) && stop_i;
        end
    end

    assign req_o     = req_q;
    assign osc_off_o = off_q;
    assign st_o      = st_q;
    assign cur_o     = cur_q;
    assign nxt_o     = nxt_q;
endmodule

// File: rtl/ccu_clk_top.sv
`timescale 1ns/1ps
module ccu_clk_top
    import ccu_pkg::*;
#(
    parameter int POST_W   = 3,
    parameter int CPU_W    = 3,
    parameter int LOWP_DIV = 16
) (
    input  logic              osc_clk_i,
    input  logic              pll_clk_i,
    input  logic              aux_clk_i,
    input  logic              rst_ni,
    input  logic              ref_half_i,
    input  logic              pll_en_i,
    input  logic [1:0]        pll_mult_code_i,
    input  logic              pll_lock_i,
    input  logic [POST_W-1:0] post_div_i,
    input  logic [1:0]        src_sel_i,
    input  logic              osc_stop_i,
    input  logic [CPU_W-1:0]  cpu_div_i,
    output logic              sys_clk_o,
    output logic              cpu_clk_o,
    output logic              pll_en_o,
    output logic [3:0]        pll_mult_o,
    output logic              osc_off_o
);
    localparam int LP_W   = $clog2(LOWP_DIV + 1);
    localparam int CPU_FW = CPU_W + 1;

    logic            ref_clk, lp_clk, pd_clk;
    logic [NSRC-1:0] leg_clk, leg_en, leg_gclk, leg_req;
    sw_st_e          st;
    src_e            cur, nxt;

    ccu_clk_div #(.W(2)) u_ref_div (
        .clk_i(osc_clk_i), .rst_ni(rst_ni),
        .fac_i(ref_half_i ? 2'd2 : 2'd1), .clk_o(ref_clk)
    );

    ccu_clk_div #(.W(LP_W)) u_lp_div (
        .clk_i(ref_clk), .rst_ni(rst_ni),
        .fac_i(LP_W'(LOWP_DIV)), .clk_o(lp_clk)
    );

    ccu_clk_div #(.W(POST_W)) u_post_div (
        .clk_i(pll_clk_i), .rst_ni(rst_ni),
        .fac_i(post_div_i), .clk_o(pd_clk)
    );

    assign leg_clk[SRC_REF16] = lp_clk;
    assign leg_clk[SRC_PLL]   = pd_clk;
    assign leg_clk[SRC_AUX]   = aux_clk_i;

    ccu_src_fsm u_fsm (
        .clk_i(osc_clk_i), .rst_ni(rst_ni), .sel_i(src_sel_i),
        .lock_i(pll_lock_i), .stop_i(osc_stop_i), .ack_i(leg_en),
        .req_o(leg_req), .osc_off_o(osc_off_o),
        .st_o(st), .cur_o(cur), .nxt_o(nxt)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_leg
        ccu_clk_leg #(.RST_ON(i == 0)) u_leg (
            .leg_clk_i(leg_clk[i]), .rst_ni(rst_ni), .req_i(leg_req[i]),
            .en_o(leg_en[i]), .gclk_o(leg_gclk[i])
        );
    end

    assign sys_clk_o = |leg_gclk;

    ccu_clk_div #(.W(CPU_FW)) u_cpu_div (
        .clk_i(sys_clk_o), .rst_ni(rst_ni),
        .fac_i({1'b0, cpu_div_i} + CPU_FW'(1)), .clk_o(cpu_clk_o)
    );

    always_ff @(posedge osc_clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pll_en_o   <= 1'b0;
            pll_mult_o <= mult_factor(2'd0);
        end else begin
            pll_en_o   <= pll_en_i;
            pll_mult_o <= mult_factor(pll_mult_code_i);
        end
    end
endmodule

// File: rtl/ccu_clk_chk.sv
`timescale 1ns/1ps
module ccu_clk_chk
    import ccu_pkg::*;
(
    input logic            osc_clk_i,
    input logic            rst_ni,
    input sw_st_e          st,
    input src_e            cur,
    input src_e            nxt,
    input logic [NSRC-1:0] leg_en,
    input logic            pll_lock_i,
    input logic [1:0]      pll_mult_code_i,
    input logic [3:0]      pll_mult_o,
    input logic            osc_off_o
);
    logic past_ok;
    always_ff @(posedge osc_clk_i or negedge rst_ni) begin
        if (!rst_ni) past_ok <= 1'b0;
        else         past_ok <= 1'b1;
    end

    assert_single_leg_R4: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
        $onehot0(leg_en));

    assert_old_off_first_R4: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
        (st == ST_START_NEW) |-> ((leg_en & ~(NSRC'(1) << cur)) == '0));

    assert_lock_guard_R5: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
        (past_ok && st == ST_STOP_OLD && $past(st) == ST_RUN && nxt == SRC_PLL)
        |-> $past(pll_lock_i));

    assert_osc_off_aux_R7: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
        osc_off_o |-> leg_en[SRC_AUX]);

    assert_mult_code_R3: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
        past_ok |-> (pll_mult_o == mult_factor($past(pll_mult_code_i))));
endmodule

bind ccu_clk_top ccu_clk_chk u_chk (
    .osc_clk_i(osc_clk_i), .rst_ni(rst_ni), .st(st), .cur(cur), .nxt(nxt),
    .leg_en(leg_en), .pll_lock_i(pll_lock_i), .pll_mult_code_i(pll_mult_code_i),
    .pll_mult_o(pll_mult_o), .osc_off_o(osc_off_o)
);

// File: tb/ccu_clk_top_test.sv
`timescale 1ns/1ps
module ccu_clk_top_test;
    logic osc_clk = 0, pll_clk = 0, aux_clk = 0, rst_n = 0;
    logic ref_half = 0, pll_en = 0, pll_lock = 0, osc_stop = 0;
    logic [1:0] mult_code = 0, src_sel = 0;
    logic [2:0] post_div = 0, cpu_div = 0;
    logic sys_clk, cpu_clk, pll_en_o, osc_off_o;
    logic [3:0] pll_mult_o;
    int checks = 0, errors = 0;

    always #5 osc_clk = ~osc_clk;
    initial begin #0.7; forever #2 pll_clk = ~pll_clk; end
    initial begin #3.1; forever #35 aux_clk = ~aux_clk; end

    ccu_clk_top uut (
        .osc_clk_i(osc_clk), .pll_clk_i(pll_clk), .aux_clk_i(aux_clk), .rst_ni(rst_n),
        .ref_half_i(ref_half), .pll_en_i(pll_en), .pll_mult_code_i(mult_code),
        .pll_lock_i(pll_lock), .post_div_i(post_div), .src_sel_i(src_sel),
        .osc_stop_i(osc_stop), .cpu_div_i(cpu_div), .sys_clk_o(sys_clk),
        .cpu_clk_o(cpu_clk), .pll_en_o(pll_en_o), .pll_mult_o(pll_mult_o),
        .osc_off_o(osc_off_o)
    );

    // pulse monitors
    realtime s_rise = -1, s_fall = -1, s_per = 0, s_hi = 0, s_min_hi = 1e9, s_min_lo = 1e9;
    realtime c_rise = -1, c_fall = -1, c_per = 0, c_hi = 0, c_min_hi = 1e9, c_min_lo = 1e9;

    always @(posedge sys_clk) begin
        if (s_rise >= 0) s_per = $realtime - s_rise;
        if (s_fall >= 0 && $realtime - s_fall < s_min_lo) s_min_lo = $realtime - s_fall;
        s_rise = $realtime;
    end
    always @(negedge sys_clk) begin
        if (s_rise >= 0) begin
            s_hi = $realtime - s_rise;
            if (s_hi < s_min_hi) s_min_hi = s_hi;
        end
        s_fall = $realtime;
    end
    always @(posedge cpu_clk) begin
        if (c_rise >= 0) c_per = $realtime - c_rise;
        if (c_fall >= 0 && $realtime - c_fall < c_min_lo) c_min_lo = $realtime - c_fall;
        c_rise = $realtime;
    end
    always @(negedge cpu_clk) begin
        if (c_rise >= 0) begin
            c_hi = $realtime - c_rise;
            if (c_hi < c_min_hi) c_min_hi = c_hi;
        end
        c_fall = $realtime;
    end

    task automatic clr_min();
        s_min_hi = 1e9; s_min_lo = 1e9; c_min_hi = 1e9; c_min_lo = 1e9;
    endtask

    task automatic chk_t(input string req, input realtime act, input realtime exp);
        checks++;
        if (act < exp - 0.5 || act > exp + 0.5) begin
            errors++;
            $display("FAIL %s: actual %0.2f expected %0.2f", req, act, exp);
        end
    endtask

    task automatic chk_min(input string req, input realtime act, input realtime lim);
        checks++;
        if (act < lim) begin
            errors++;
            $display("FAIL %s: actual %0.2f expected >= %0.2f", req, act, lim);
        end
    endtask

    task automatic chk_v(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic settle(); #3003; endtask

    task automatic t_reset();
        settle();
        chk_t("R1 sys period", s_per, 160); chk_t("R1 sys high", s_hi, 80);
        chk_t("R1 cpu period", c_per, 160);
        chk_v("R1 pll_en_o", pll_en_o, 0); chk_v("R1 osc_off_o", osc_off_o, 0);
        chk_v("R1 pll_mult_o", pll_mult_o, 6);
    endtask

    task automatic t_mult();
        pll_en = 1; mult_code = 2'd3; #33;
        chk_v("R3 pll_en_o", pll_en_o, 1); chk_v("R3 mult code3", pll_mult_o, 14);
        mult_code = 2'd1; #33; chk_v("R3 mult code1", pll_mult_o, 8);
        mult_code = 2'd2; #33; chk_v("R3 mult code2", pll_mult_o, 10);
    endtask

    task automatic t_div2();
        ref_half = 1; settle();
        chk_t("R2 sys period", s_per, 320); chk_t("R2 sys high", s_hi, 160);
    endtask

    task automatic t_lock();
        post_div = 3'd3; clr_min();
        src_sel = 2'd1; settle();
        chk_t("R5 held w/o lock", s_per, 320);
        pll_lock = 1; settle();
        chk_t("R6 div3 period", s_per, 12); chk_t("R6 div3 high", s_hi, 4);
        chk_min("R4 min high", s_min_hi, 3.9); chk_min("R4 min low", s_min_lo, 3.9);
    endtask

    task automatic t_postdiv();
        post_div = 3'd4; settle();
        chk_t("R6 div4 period", s_per, 16); chk_t("R6 div4 high", s_hi, 8);
        post_div = 3'd1; settle();
        chk_t("R6 div1 period", s_per, 4);
        post_div = 3'd0; settle();
        chk_t("R6 code0 period", s_per, 4); chk_t("R6 code0 high", s_hi, 2);
        post_div = 3'd7; settle();
        chk_t("R6 div7 period", s_per, 28); chk_t("R6 div7 high", s_hi, 4);
    endtask

    task automatic t_presc();
        post_div = 3'd4; cpu_div = 3'd0; settle();
        chk_t("R8 code0 cpu period", c_per, 16); chk_t("R8 code0 cpu high", c_hi, 8);
        cpu_div = 3'd2; settle();
        chk_t("R8 code2 cpu period", c_per, 48); chk_t("R8 code2 cpu high", c_hi, 16);
        clr_min(); cpu_div = 3'd7; settle();
        chk_t("R8 code7 cpu period", c_per, 128); chk_t("R8 code7 cpu high", c_hi, 64);
        chk_min("R9 cpu min high", c_min_hi, 15.9); chk_min("R9 cpu min low", c_min_lo, 15.9);
    endtask

    task automatic t_aux();
        post_div = 3'd3; settle(); clr_min();
        src_sel = 2'd2; settle();
        chk_t("R7 aux period", s_per, 70); chk_t("R7 aux high", s_hi, 35);
        chk_v("R7 osc_off idle", osc_off_o, 0);
        osc_stop = 1; #53; chk_v("R7 osc_off set", osc_off_o, 1);
        src_sel = 2'd1; settle();
        chk_t("R7 stay on aux", s_per, 70);
        osc_stop = 0; #53; chk_v("R7 osc_off clear", osc_off_o, 0);
        settle();
        chk_t("R7 back to pll", s_per, 12);
        chk_min("R4 switch min high", s_min_hi, 3.9); chk_min("R4 switch min low", s_min_lo, 3.9);
    endtask

    task automatic t_code3();
        clr_min(); src_sel = 2'd3; settle();
        chk_t("R10 code3 period", s_per, 320); chk_t("R10 code3 high", s_hi, 160);
        chk_min("R4 to ref min high", s_min_hi, 3.9);
    endtask

    initial begin
        #53 rst_n = 1;
        t_reset();
        t_mult();
        t_div2();
        t_lock();
        t_postdiv();
        t_presc();
        t_aux();
        t_code3();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1500000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule